// File: doc/BRIEF.md
# Error Flag Port Scanner

This controller sits between the multiplexed flag port of a video error-detection coprocessor and a bank of status LEDs. It steps a two-bit select bus through the port's four positions, one position per dwell period. On the last cycle of each dwell it captures the four-bit error word the port returns. It steers that word into one of three LED registers: ancillary-data errors, full-field errors or active-picture errors. The fourth position is reserved, and its data is discarded.

The controller also holds a one-way direction mode. After reset it shows the errors of the outgoing stream. A debounced press of the incoming-flags button issues a single write command to the port, which switches it to the incoming stream. From then on the button does nothing, and only reset brings back outgoing mode. The field, vertical-blank and horizontal-blank timing inputs each pass through one register to their own LED.

Top module: `edh_flag_scanner`

## Requirements
- R1: After reset `sel_out` is 0. It increments by one modulo 4 every 2^DWELL_LG clock cycles, so after k rising edges since reset release it equals (k >> DWELL_LG) mod 4.
- R2: `flag_in` is captured on the last cycle of each dwell. Select value 0 loads `led_anc`, 1 loads `led_ff` and 2 loads `led_ap`.
- R3: Data returned at select value 3 never reaches any LED register.
- R4: An LED register keeps its value until its own position is captured again. New data at another position does not change it.
- R5: Reset is synchronous and active-high. It sets `sel_out`, all three flag LEDs, `cmd_we` and `cmd_dir` to 0, and 0 on `cmd_dir` means outgoing mode.
- R6: A button press held stable for 2^DEB_LG cycles while in outgoing mode produces exactly one `cmd_we` pulse, one cycle wide. `cmd_dir` is 1 (incoming) from that cycle on.
- R7: In incoming mode, further presses produce no `cmd_we` pulse and leave `cmd_dir` at 1. Only reset returns `cmd_dir` to 0.
- R8: A button level that lasts fewer than 2^DEB_LG cycles is ignored: no `cmd_we` pulse and no change of `cmd_dir`.
- R9: `led_fld`, `led_vblk` and `led_hblk` equal `fld_in`, `vblk_in` and `hblk_in` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_in | input | FLAG_W | Error word returned by the flag port |
| btn_in | input | 1 | Asynchronous incoming-flags button, active high |
| fld_in | input | 1 | Field timing input |
| vblk_in | input | 1 | Vertical blanking input |
| hblk_in | input | 1 | Horizontal blanking input |
| sel_out | output | 2 | Flag port position select |
| cmd_we | output | 1 | One-cycle write strobe to the flag port |
| cmd_dir | output | 1 | Direction bit: 0 outgoing, 1 incoming |
| led_anc | output | FLAG_W | Ancillary-data error LEDs |
| led_ff | output | FLAG_W | Full-field error LEDs |
| led_ap | output | FLAG_W | Active-picture error LEDs |
| led_fld | output | 1 | Field LED |
| led_vblk | output | 1 | Vertical blanking LED |
| led_hblk | output | 1 | Horizontal blanking LED |

## Verification
A select counter that drifts or wraps wrongly shows on `sel_out` within one dwell period. Within the next scan it also shows as LED data from the wrong position, including the reserved one. A demultiplexer fault shows within one full scan of 4·2^DWELL_LG cycles as a group LED that holds another group's word, or that changes outside its own capture. A debouncer or mode fault shows within 2^DEB_LG plus about three cycles of a press, as a missing, repeated or premature `cmd_we` pulse, or as `cmd_dir` falling without reset.

// File: rtl/edh_scan_pkg.sv
package edh_scan_pkg;
  typedef enum logic [1:0] {
    POS_ANC = 2'd0,
    POS_FF  = 2'd1,
    POS_AP  = 2'd2,
    POS_RSV = 2'd3
  } scan_pos_e;

  localparam int NUM_GROUPS = 3;
  localparam int SEL_W      = 2;
endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import edh_scan_pkg::*;
#(
  parameter int DWELL_LG = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [SEL_W-1:0] sel,
  output logic             stb
);
  localparam logic [DWELL_LG-1:0] DWELL_MAX = {DWELL_LG{1'b1}};

  logic [DWELL_LG-1:0] dwell_q;
  logic [SEL_W-1:0]    sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell_q <= '0;
      sel_q   <= '0;
    end else begin
      dwell_q <= dwell_q + 1'b1;
      if (dwell_q == DWELL_MAX) sel_q <= sel_q + 1'b1;
    end
  end

  assign sel = sel_q;
  assign stb = (dwell_q == DWELL_MAX);

  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(stb)) |-> $stable(sel_q));
  // R1
  sel_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(stb)) |-> (sel_q == SEL_W'($past(sel_q) + 1'b1)));
endmodule

// File: rtl/flag_bank.sv
module flag_bank
  import edh_scan_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             stb,
  input  logic [SEL_W-1:0]                 pos,
  input  logic [FLAG_W-1:0]                flag,
  output logic [NUM_GROUPS-1:0][FLAG_W-1:0] led
);
  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (rst) led[g] <= '0;
        else if (stb && (pos == SEL_W'(g))) led[g] <= flag;
      end

      // R4
      grp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !($past(stb) && ($past(pos) == SEL_W'(g))))
          |-> $stable(led[g]));
      // R2
      grp_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(stb) && ($past(pos) == SEL_W'(g)))
          |-> (led[g] == $past(flag)));
    end
  endgenerate

  // R3
  rsv_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(pos) == POS_RSV) |-> $stable(led));
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_LG = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_async,
  output logic rise
);
  localparam logic [DEB_LG-1:0] DEB_MAX = {DEB_LG{1'b1}};

  logic          s1_q, s2_q, lvl_q, rise_q;
  logic [DEB_LG-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      rise_q <= 1'b0;
    end else begin
      s1_q   <= btn_async;
      s2_q   <= s1_q;
      rise_q <= 1'b0;
      if (s2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == DEB_MAX) begin
        cnt_q  <= '0;
        lvl_q  <= s2_q;
        rise_q <= s2_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rise = rise_q;

  // R8
  lvl_change_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && (lvl_q != $past(lvl_q))) |-> ($past(cnt_q) == DEB_MAX));
  // R6
  rise_width_chk: assert property (@(posedge clk) disable iff (rst)
    rise_q |=> !rise_q);
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic press,
  output logic we,
  output logic dir
);
  logic dir_q, we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      we_q <= press && !dir_q;
      if (press) dir_q <= 1'b1;
    end
  end

  assign we  = we_q;
  assign dir = dir_q;

  // R7
  dir_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> !$fell(dir_q));
  // R6
  we_once_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && we_q) |-> (dir_q && !$past(dir_q)));
endmodule

// File: rtl/edh_flag_scanner.sv
module edh_flag_scanner
  import edh_scan_pkg::*;
#(
  parameter int DWELL_LG = 3,
  parameter int DEB_LG   = 4,
  parameter int FLAG_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic              btn_in,
  input  logic              fld_in,
  input  logic              vblk_in,
  input  logic              hblk_in,
  output logic [1:0]        sel_out,
  output logic              cmd_we,
  output logic              cmd_dir,
  output logic [FLAG_W-1:0] led_anc,
  output logic [FLAG_W-1:0] led_ff,
  output logic [FLAG_W-1:0] led_ap,
  output logic              led_fld,
  output logic              led_vblk,
  output logic              led_hblk
);
  logic                              stb;
  logic [SEL_W-1:0]                  sel;
  logic                              press;
  logic [NUM_GROUPS-1:0][FLAG_W-1:0] leds;
  logic [2:0]                        tim_q;

  scan_seq #(.DWELL_LG(DWELL_LG)) u_seq (
    .clk(clk), .rst(rst), .sel(sel), .stb(stb)
  );

  flag_bank #(.FLAG_W(FLAG_W)) u_bank (
    .clk(clk), .rst(rst), .stb(stb), .pos(sel), .flag(flag_in), .led(leds)
  );

  btn_debounce #(.DEB_LG(DEB_LG)) u_deb (
    .clk(clk), .rst(rst), .btn_async(btn_in), .rise(press)
  );

  mode_ctrl u_mode (
    .clk(clk), .rst(rst), .press(press), .we(cmd_we), .dir(cmd_dir)
  );

  always_ff @(posedge clk) begin
    if (rst) tim_q <= '0;
    else     tim_q <= {hblk_in, vblk_in, fld_in};
  end

  assign sel_out  = sel;
  assign led_anc  = leds[POS_ANC];
  assign led_ff   = leds[POS_FF];
  assign led_ap   = leds[POS_AP];
  assign led_fld  = tim_q[0];
  assign led_vblk = tim_q[1];
  assign led_hblk = tim_q[2];

  // R9
  tim_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (led_vblk == $past(vblk_in)));
endmodule

// File: tb/tb_edh_flag_scanner.sv
`timescale 1ns/1ps
module tb_edh_flag_scanner;
  localparam int DWELL_LG = 3;
  localparam int DEB_LG   = 4;
  localparam int FLAG_W   = 4;
  localparam int DWELL    = 1 << DWELL_LG;
  localparam int DEB      = 1 << DEB_LG;
  localparam int SCAN     = 4 * DWELL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_in = 1'b0, fld_in = 1'b0, vblk_in = 1'b0, hblk_in = 1'b0;
  logic [FLAG_W-1:0] tbl [4];
  logic [FLAG_W-1:0] flag_in;
  logic [1:0] sel_out;
  logic cmd_we, cmd_dir, led_fld, led_vblk, led_hblk;
  logic [FLAG_W-1:0] led_anc, led_ff, led_ap;

  int checks = 0, fails = 0, we_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign flag_in = tbl[sel_out];

  edh_flag_scanner #(.DWELL_LG(DWELL_LG), .DEB_LG(DEB_LG), .FLAG_W(FLAG_W)) dut (
    .clk(clk), .rst(rst), .flag_in(flag_in), .btn_in(btn_in),
    .fld_in(fld_in), .vblk_in(vblk_in), .hblk_in(hblk_in),
    .sel_out(sel_out), .cmd_we(cmd_we), .cmd_dir(cmd_dir),
    .led_anc(led_anc), .led_ff(led_ff), .led_ap(led_ap),
    .led_fld(led_fld), .led_vblk(led_vblk), .led_hblk(led_hblk)
  );

  always @(negedge clk) if (!rst && cmd_we) we_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_sel(input int k);
    return (k >> DWELL_LG) % 4;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_leds(input string req);
    chk(led_anc == tbl[0], req, led_anc, tbl[0]);
    chk(led_ff  == tbl[1], req, led_ff,  tbl[1]);
    chk(led_ap  == tbl[2], req, led_ap,  tbl[2]);
  endtask

  task automatic hold_btn(input bit v, input int n);
    @(negedge clk); btn_in = v;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0021));
    for (int i = 0; i < 4; i++) tbl[i] = '0;
    repeat (2) @(negedge clk);
    // R5: reset state
    chk(sel_out == 0 && cmd_we == 0 && cmd_dir == 0, "R5", {sel_out, cmd_we, cmd_dir}, 0);
    chk(led_anc == 0 && led_ff == 0 && led_ap == 0, "R5", {led_anc, led_ff, led_ap}, 0);
    tbl[0] = 4'h1; tbl[1] = 4'h2; tbl[2] = 4'h4; tbl[3] = 4'hF;
    rst = 1'b0;
    // R1: select sequence counted from reset release
    for (int k = 1; k <= 2 * SCAN; k++) begin
      @(negedge clk);
      if (sel_out != 2'(exp_sel(k))) chk(1'b0, "R1", sel_out, exp_sel(k));
    end
    chk(sel_out == 2'(exp_sel(2 * SCAN)), "R1", sel_out, exp_sel(2 * SCAN));
    // R2, R3: directed mapping with distinct reserved word
    check_leds("R2");
    chk(led_anc != 4'hF && led_ff != 4'hF && led_ap != 4'hF, "R3", led_ap, 0);
    tbl[0] = 4'h0; tbl[1] = 4'h0; tbl[2] = 4'h0; tbl[3] = 4'hA;
    repeat (2 * SCAN) @(negedge clk);
    chk(led_anc == 0 && led_ff == 0 && led_ap == 0, "R3", {led_anc, led_ff, led_ap}, 0);
    // R4: change position 0 data while another position is selected
    tbl[0] = 4'h9;
    while (sel_out != 2'd1) @(negedge clk);
    tbl[0] = 4'h6;
    while (sel_out != 2'd0) begin
      if (led_anc != 4'h9) chk(1'b0, "R4", led_anc, 4'h9);
      @(negedge clk);
    end
    chk(led_anc == 4'h9, "R4", led_anc, 4'h9);
    repeat (SCAN) @(negedge clk);
    chk(led_anc == 4'h6, "R4", led_anc, 4'h6);
    // R2: random words per scan
    for (int it = 0; it < 12; it++) begin
      for (int i = 0; i < 4; i++) tbl[i] = 4'($urandom);
      repeat (2 * SCAN) @(negedge clk);
      check_leds("R2");
    end
    // R9: random timing inputs
    for (int it = 0; it < 24; it++) begin
      logic [2:0] r;
      r = 3'($urandom);
      fld_in = r[0]; vblk_in = r[1]; hblk_in = r[2];
      @(negedge clk);
      chk({led_hblk, led_vblk, led_fld} == r, "R9", {led_hblk, led_vblk, led_fld}, r);
    end
    // R8: short pulse ignored
    hold_btn(1'b1, DEB / 2);
    hold_btn(1'b0, 2 * DEB);
    chk(we_cnt == 0 && cmd_dir == 0, "R8", we_cnt, 0);
    // R6: long press yields one pulse
    hold_btn(1'b1, 3 * DEB);
    chk(we_cnt == 1, "R6", we_cnt, 1);
    chk(cmd_dir == 1'b1, "R6", cmd_dir, 1);
    hold_btn(1'b0, 2 * DEB);
    // R7: second press ignored
    hold_btn(1'b1, 3 * DEB);
    hold_btn(1'b0, 2 * DEB);
    chk(we_cnt == 1, "R7", we_cnt, 1);
    chk(cmd_dir == 1'b1, "R7", cmd_dir, 1);
    // R7: reset restores outgoing, a new press works again
    do_reset();
    @(negedge clk);
    chk(cmd_dir == 1'b0, "R7", cmd_dir, 0);
    we_cnt = 0;
    hold_btn(1'b1, 3 * DEB);
    hold_btn(1'b0, 2 * DEB);
    chk(we_cnt == 1 && cmd_dir == 1'b1, "R6", we_cnt, 1);
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 200000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule